// File: doc/BRIEF.md
# Single-Wire Telemetry Frame Serializer

This block turns each finished ADC conversion into a self-clocked serial frame on one output wire. A frame carries the channel tag of the conversion, its 10-bit result, three fault flags (overcurrent, undervoltage, overvoltage) and an even parity bit. The frame is built and started automatically when the conversion-done strobe is seen. No request or handshake from a receiver is involved. The line rests high between frames.

Every bit occupies one cell of `2*HALF_CYC` system clocks. Each cell carries a transition at its centre, so a receiver can recover the bit timing from the data alone. A strobe that arrives while a frame is on the wire is parked in a per-channel slot. A later strobe for the same channel replaces what is parked there. Parked channels are sent one after another, and the channel after the one sent last is served first.

The control machine has four states:
- `ST_IDLE`: the line is high and the machine waits for a parked channel.
- `ST_HALF_A`: the first half of a cell.
- `ST_HALF_B`: the second half of a cell.
- `ST_GAP`: one full cell of forced high line after the last cell.

It moves through these transitions:
- load: `ST_IDLE` to `ST_HALF_A`.
- mid-cell: `ST_HALF_A` to `ST_HALF_B`.
- next-bit: `ST_HALF_B` to `ST_HALF_A`.
- frame-end: `ST_HALF_B` to `ST_GAP`.
- release: `ST_GAP` to `ST_IDLE`.

The half-cell timer is cleared on the load transition, so cell boundaries are fixed relative to the frame start.

Top module: `telem_frame_tx`

## Requirements
- R1: After reset, and at all times while no frame is in progress, `line_out` is 1.
- R2: When the block is idle with nothing parked, a strobe sampled on clock edge k makes `line_out` fall right after edge k+1. That low level is the first half of the start cell.
- R3: A frame is 18 cells sent in this order: start bit 0, marker bit 1, channel bit 1, channel bit 0, data bit 9 down to data bit 0, overcurrent flag, undervoltage flag, overvoltage flag, parity.
- R4: The parity bit makes the number of ones among the 2 channel bits, the 10 data bits, the 3 flags and the parity bit even.
- R5: Each cell lasts exactly 2*HALF_CYC clocks. A 1 is high for the first HALF_CYC clocks and then low. A 0 is low first and then high.
- R6: After the last cell of a frame, `line_out` stays high for at least 2*HALF_CYC clocks before the next frame starts.
- R7: A strobe that arrives during a frame is not lost. Its channel is sent after the current frame ends.
- R8: If several strobes arrive for one channel while that channel waits, exactly one frame is sent for it, and it carries the values of the last of those strobes.
- R9: When several channels are waiting, they are sent in increasing channel order, wrapping around, starting with the channel after the one sent last. After reset the search starts at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe marking the end of a conversion |
| conv_ch | input | 2 | Channel number of the finished conversion |
| conv_data | input | 10 | Conversion result |
| flt_oc | input | 1 | Overcurrent flag |
| flt_uv | input | 1 | Undervoltage flag |
| flt_ov | input | 1 | Overvoltage flag |
| line_out | output | 1 | Encoded serial output, high when idle |

## Verification
The hardest situation to create from the ports is a queue of several parked channels. The queue must hold a channel that was overwritten while it waited, and it must be served in rotated order. The stimulus gets there by starting one frame and then firing a burst of strobes while that frame is still on the wire: channel 2, channel 0, channel 2 again with new data, then channel 3. The decoder must then see channels 2, 3 and 0 in that order, with the later channel-2 data, and no further frame. Single frames sweep every channel against every fault-flag combination, and a walking-one data pattern covers each data bit position. The bench decoder checks every clock of every cell for level and width.

// File: rtl/telem_pkg.sv
package telem_pkg;

    // Fault flags in the order they leave the wire
    typedef struct packed {
        logic oc;
        logic uv;
        logic ov;
    } telem_flt_t;

    localparam int unsigned FLT_W = 3;

    // Control states of the serializer
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HALF_A = 2'd1,
        ST_HALF_B = 2'd2,
        ST_GAP    = 2'd3
    } tx_state_t;

endpackage

// File: rtl/telem_half_timer.sv
module telem_half_timer #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/telem_slot_bank.sv
module telem_slot_bank
    import telem_pkg::*;
#(
    parameter int unsigned CH_W   = 2,
    parameter int unsigned DATA_W = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [CH_W-1:0]                   wr_ch,
    input  logic [DATA_W-1:0]                 wr_data,
    input  telem_flt_t                        wr_flt,
    input  logic                              rd_clr,
    input  logic [CH_W-1:0]                   rd_ch,
    output logic [(1<<CH_W)-1:0]              pend_mask,
    output logic [(1<<CH_W)-1:0][DATA_W-1:0]  slot_data,
    output telem_flt_t [(1<<CH_W)-1:0]        slot_flt
);
    localparam int unsigned NUM_CH = 1 << CH_W;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic hit_wr;
        logic hit_clr;
        assign hit_wr  = wr_en  && (wr_ch == CH_W'(g));
        assign hit_clr = rd_clr && (rd_ch == CH_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_mask[g] <= 1'b0;
                slot_data[g] <= '0;
                slot_flt[g]  <= '0;
            end else if (hit_wr) begin
                // a fresh sample wins over a clear in the same cycle
                pend_mask[g] <= 1'b1;
                slot_data[g] <= wr_data;
                slot_flt[g]  <= wr_flt;
            end else if (hit_clr) begin
                pend_mask[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/telem_rr_pick.sv
module telem_rr_pick #(
    parameter int unsigned CH_W = 2
) (
    input  logic [(1<<CH_W)-1:0] pend_mask,
    input  logic [CH_W-1:0]      last_ch,
    output logic                 grant_vld,
    output logic [CH_W-1:0]      grant_ch
);
    localparam int unsigned NUM_CH = 1 << CH_W;

    always_comb begin
        grant_vld = 1'b0;
        grant_ch  = '0;
        for (int off = 1; off <= NUM_CH; off++) begin
            logic [CH_W-1:0] idx;
            idx = last_ch + CH_W'(off);
            if (!grant_vld && pend_mask[idx]) begin
                grant_vld = 1'b1;
                grant_ch  = idx;
            end
        end
    end
endmodule

// File: rtl/telem_frame_fsm.sv
module telem_frame_fsm
    import telem_pkg::*;
#(
    parameter int unsigned CH_W   = 2,
    parameter int unsigned DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_vld,
    input  logic [CH_W-1:0]   grant_ch,
    input  logic [DATA_W-1:0] sel_data,
    input  telem_flt_t        sel_flt,
    input  logic              half_tick,
    output logic              take,
    output logic [CH_W-1:0]   last_ch,
    output logic              busy,
    output logic              line_out
);
    localparam int unsigned PAY_W      = CH_W + DATA_W + FLT_W;
    localparam int unsigned FRAME_BITS = PAY_W + 3;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

    tx_state_t state_q, state_d;
    logic [FRAME_BITS-1:0] frame_q;
    logic [IDX_W-1:0]      bit_idx_q;
    logic                  gap_half_q;
    logic                  line_q;
    logic [CH_W-1:0]       last_q;

    logic [PAY_W-1:0]      payload;
    logic [FRAME_BITS-1:0] frame_new;

    assign payload   = {grant_ch, sel_data, sel_flt};
    assign frame_new = {1'b0, 1'b1, payload, ^payload};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (grant_vld) state_d = ST_HALF_A;
            ST_HALF_A: if (half_tick) state_d = ST_HALF_B;
            ST_HALF_B: if (half_tick) state_d = (bit_idx_q == LAST_BIT) ? ST_GAP : ST_HALF_A;
            ST_GAP:    if (half_tick && gap_half_q) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q    <= '0;
            bit_idx_q  <= '0;
            gap_half_q <= 1'b0;
            line_q     <= 1'b1;
            last_q     <= '1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    line_q <= 1'b1;
                    if (grant_vld) begin
                        frame_q   <= frame_new;
                        bit_idx_q <= '0;
                        line_q    <= frame_new[FRAME_BITS-1];
                        last_q    <= grant_ch;
                    end
                end
                ST_HALF_A: begin
                    if (half_tick) line_q <= ~frame_q[FRAME_BITS-1];
                end
                ST_HALF_B: begin
                    if (half_tick) begin
                        if (bit_idx_q == LAST_BIT) begin
                            line_q     <= 1'b1;
                            gap_half_q <= 1'b0;
                        end else begin
                            frame_q   <= frame_q << 1;
                            bit_idx_q <= bit_idx_q + 1'b1;
                            line_q    <= frame_q[FRAME_BITS-2];
                        end
                    end
                end
                ST_GAP: begin
                    line_q <= 1'b1;
                    if (half_tick) gap_half_q <= 1'b1;
                end
                default: line_q <= 1'b1;
            endcase
        end
    end

    assign take     = (state_q == ST_IDLE) && grant_vld;
    assign busy     = (state_q != ST_IDLE);
    assign line_out = line_q;
    assign last_ch  = last_q;
endmodule

// File: rtl/telem_frame_tx.sv
module telem_frame_tx
    import telem_pkg::*;
#(
    parameter int unsigned CH_W     = 2,
    parameter int unsigned DATA_W   = 10,
    parameter int unsigned HALF_CYC = 4085
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   conv_ch,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              flt_oc,
    input  logic              flt_uv,
    input  logic              flt_ov,
    output logic              line_out
);
    localparam int unsigned NUM_CH = 1 << CH_W;

    logic                             half_tick;
    logic                             take;
    logic                             tx_busy;
    logic                             grant_vld;
    logic [CH_W-1:0]                  grant_ch;
    logic [CH_W-1:0]                  last_ch;
    logic [NUM_CH-1:0]                pend_mask;
    logic [NUM_CH-1:0][DATA_W-1:0]    slot_data;
    telem_flt_t [NUM_CH-1:0]          slot_flt;
    telem_flt_t                       in_flt;
    logic                             pend_any;

    assign in_flt   = '{oc: flt_oc, uv: flt_uv, ov: flt_ov};
    assign pend_any = |pend_mask;

    telem_half_timer #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take),
        .tick  (half_tick)
    );

    telem_slot_bank #(.CH_W(CH_W), .DATA_W(DATA_W)) slots_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (conv_done),
        .wr_ch     (conv_ch),
        .wr_data   (conv_data),
        .wr_flt    (in_flt),
        .rd_clr    (take),
        .rd_ch     (grant_ch),
        .pend_mask (pend_mask),
        .slot_data (slot_data),
        .slot_flt  (slot_flt)
    );

    telem_rr_pick #(.CH_W(CH_W)) pick_i (
        .pend_mask (pend_mask),
        .last_ch   (last_ch),
        .grant_vld (grant_vld),
        .grant_ch  (grant_ch)
    );

    telem_frame_fsm #(.CH_W(CH_W), .DATA_W(DATA_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_vld (grant_vld),
        .grant_ch  (grant_ch),
        .sel_data  (slot_data[grant_ch]),
        .sel_flt   (slot_flt[grant_ch]),
        .half_tick (half_tick),
        .take      (take),
        .last_ch   (last_ch),
        .busy      (tx_busy),
        .line_out  (line_out)
    );
endmodule

// File: rtl/telem_frame_tx_chk.sv
module telem_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_done,
    input logic line_out,
    input logic busy,
    input logic half_tick,
    input logic pend_any
);
    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_out);

    // R2
    prompt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_any && !busy) |=> busy);

    // R5
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(half_tick)) |-> $stable(line_out));

    // R7
    park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && busy) |=> pend_any);
endmodule

bind telem_frame_tx telem_frame_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .line_out  (line_out),
    .busy      (tx_busy),
    .half_tick (half_tick),
    .pend_any  (pend_any)
);

// File: tb/telem_frame_tx_tb.sv
`timescale 1ns/1ps
module telem_frame_tx_tb_top;
    localparam int H  = 4;
    localparam int NB = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [1:0] conv_ch = '0;
    logic [9:0] conv_data = '0;
    logic       flt_oc = 1'b0, flt_uv = 1'b0, flt_ov = 1'b0;
    logic       line_out;

    always #2 clk = ~clk;

    telem_frame_tx #(.CH_W(2), .DATA_W(10), .HALF_CYC(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_ch(conv_ch),
        .conv_data(conv_data), .flt_oc(flt_oc), .flt_uv(flt_uv), .flt_ov(flt_ov),
        .line_out(line_out)
    );

    int checks = 0, errors = 0;
    int nexp = 0, nrx = 0;
    logic [NB-1:0] exp_q [0:127];
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [NB-1:0] mk(input logic [1:0] ch, input logic [9:0] d,
                                         input logic [2:0] f);
        logic [14:0] p;
        p = {ch, d, f};
        return {1'b0, 1'b1, p, ^p};
    endfunction

    // Decoder on the line
    initial begin : monitor
        int idle_run;
        idle_run = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (line_out) begin
                idle_run++;
            end else begin
                logic [NB-1:0] word;
                bit shape_ok;
                if (nrx > 0)
                    chk(idle_run >= 2*H, "R6", "idle cycles between frames", idle_run, 2*H);
                shape_ok = 1;
                for (int b = 0; b < NB; b++) begin
                    logic first;
                    for (int k = 0; k < 2*H; k++) begin
                        if (!(b == 0 && k == 0)) @(negedge clk);
                        if (k == 0) first = line_out;
                        else if (k < H && line_out != first) shape_ok = 0;
                        else if (k >= H && line_out == first) shape_ok = 0;
                    end
                    word[NB-1-b] = first;
                end
                chk(shape_ok, "R5", "cell shape and width", nrx, 1);
                chk(^word[15:0] == 1'b0, "R4", "even parity", word, word ^ 1);
                chk(word == exp_q[nrx], "R3", "frame content", word, exp_q[nrx]);
                nrx++;
                idle_run = 0;
            end
        end
    end

    task automatic strobe(input logic [1:0] ch, input logic [9:0] d, input logic [2:0] f);
        @(negedge clk);
        conv_done = 1'b1; conv_ch = ch; conv_data = d;
        {flt_oc, flt_uv, flt_ov} = f;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic drain();
        while (nrx < nexp) @(negedge clk);
        repeat (2*H + 2) @(negedge clk);
        chk(line_out == 1'b1, "R1", "line high after frame", line_out, 1);
    endtask

    task automatic send_idle(input logic [1:0] ch, input logic [9:0] d, input logic [2:0] f);
        exp_q[nexp] = mk(ch, d, f);
        nexp++;
        strobe(ch, d, f);
        chk(line_out == 1'b1, "R2", "line one edge after strobe", line_out, 1);
        @(negedge clk);
        chk(line_out == 1'b0, "R2", "line two edges after strobe", line_out, 0);
        drain();
    endtask

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(line_out == 1'b1, "R1", "line during reset", line_out, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(line_out == 1'b1, "R1", "line idle after reset", line_out, 1);

        // every channel against every flag combination
        for (int ch = 0; ch < 4; ch++)
            for (int f = 0; f < 8; f++)
                send_idle(2'(ch), 10'((ch*97 + f*131 + 5) & 10'h3ff), 3'(f));
        // walking one over the data bits, plus extremes
        for (int b = 0; b < 10; b++)
            send_idle(2'(b % 4), 10'(1 << b), 3'(b % 8));
        send_idle(2'd3, 10'h3ff, 3'b111);
        send_idle(2'd0, 10'h000, 3'b000);

        // R7 R8 R9: strobes parked while a frame is on the wire
        exp_q[nexp] = mk(2'd1, 10'h155, 3'b010); nexp++;
        strobe(2'd1, 10'h155, 3'b010);
        strobe(2'd2, 10'h0aa, 3'b001);
        strobe(2'd0, 10'h123, 3'b100);
        strobe(2'd2, 10'h2c3, 3'b011);
        strobe(2'd3, 10'h3c0, 3'b110);
        exp_q[nexp] = mk(2'd2, 10'h2c3, 3'b011); nexp++;
        exp_q[nexp] = mk(2'd3, 10'h3c0, 3'b110); nexp++;
        exp_q[nexp] = mk(2'd0, 10'h123, 3'b100); nexp++;
        drain();
        repeat (400) @(negedge clk);
        chk(nrx == nexp, "R8", "frame count after parked burst", nrx, nexp);
        chk(line_out == 1'b1, "R1", "line idle at end", line_out, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d frames expected %0d", nrx, nexp);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule